// File: doc/BRIEF.md
# Variable Pulse Width Symbol Transceiver

This block moves single-wire bus traffic one bit at a time, with the bit value carried by the width of each pulse. It drives a digital transmit line and watches a digital receive line that comes back through an external line driver. That receive line is inverted relative to the transmit line and delayed. The receive line is cleaned by a short majority-style filter. Every symbol is then timed from the most recent accepted receive transition, and each completed receive segment is decoded into a start-of-frame, a data bit, or an end of frame.

When the block transmits, it anchors its own symbol timing to the echo, not to its own edges. It compares every echoed symbol with the one it sent. An active level from another node overrides a passive level, so a node that sent a passive symbol and sees it cut short has lost arbitration and withdraws. A host feeds transmit bits through a ready/valid pair and collects decoded bits from a strobe. A speed input runs every symbol time four times faster.

Top module: `vpw_sym_xcvr`

## Requirements
- R1: After reset, txOut, txBusy, collision, noEcho and rxBitValid are low, and busIdle stays low until the receive line has been passive for the idle time.
- R2: A receive pulse shorter than FILT_N consecutive tick samples (3 by default) is ignored: it neither clears busIdle nor produces a decoded bit.
- R3: busIdle is high when the filtered receive line (passive = rxIn high) has been passive for at least IDLE_T time units (300), and it drops after an accepted active transition.
- R4: When no frame is in progress, txReady equals busIdle. The bit accepted under that condition starts a frame by driving txOut high (active) as a start-of-frame symbol.
- R5: Each transmitted symbol lasts its nominal time counted from the echoed receive transition that began it: start-of-frame 200, short 64 and long 128 units, plus the loop delay.
- R6: Data symbols alternate in level, and the first one after start-of-frame is passive. Bit 0 is sent as a long active or a short passive symbol. Bit 1 is sent as a short active or a long passive symbol.
- R7: After an active segment of at least 164 units (start-of-frame), each completed segment shorter than 96 units is decoded as short and each shorter than 164 as long, using the encoding of R6. Each such segment gives one rxBitValid pulse with rxBit. A passive segment of 164 or more ends the frame.
- R8: txReady is raised again as each data symbol is loaded, so the host supplies the next bit. If no bit is pending when the current symbol ends, the frame ends and txBusy drops.
- R9: An echoed symbol whose level or width class differs from the one sent sets collision, forces txOut low and ends the frame. collision stays set until busIdle is seen.
- R10: If txOut is active and the receive line stays passive for LONG_T units, noEcho is set and the frame ends. noEcho is cleared when the next frame starts.
- R11: With fastMode high, every time unit advances four per tick, so all symbol and idle times shrink by four in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable from the prescaler |
| fastMode | input | 1 | Four-times symbol rate |
| rxIn | input | 1 | Echoed bus line, low while the bus is active |
| txValid | input | 1 | Host offers a transmit bit |
| txBit | input | 1 | Transmit bit value |
| txReady | output | 1 | Block accepts a transmit bit this cycle |
| txOut | output | 1 | Transmit line, high for an active symbol |
| txBusy | output | 1 | A transmitted frame is in progress |
| rxBitValid | output | 1 | One-cycle strobe for a decoded bit |
| rxBit | output | 1 | Decoded bit value |
| collision | output | 1 | Arbitration lost, held until bus idle |
| noEcho | output | 1 | Active transmit pulse was never echoed |
| busIdle | output | 1 | Bus passive for the idle time |

## Verification
The bench builds the block with its default symbol times of 64, 128, 200 and 300 units, a three-sample filter, and a tick every fourth clock. This keeps a full normal-rate frame at a few thousand clocks, so several frames fit in the run. An echo path of one tick of delay puts the decode widths about six ticks above nominal. That is well inside the 96 and 164 splits at both speeds, so short, long and start-of-frame segments decode in both modes. A second node modelled in the bench drives the line to force a lost arbitration and to send a receive-only frame whose widths sit four units on either side of the short/long split.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

  typedef enum logic [1:0] {
    CLS_SHORT,
    CLS_LONG,
    CLS_SOF,
    CLS_BREAK
  } symCls_t;

  // datapath -> control
  typedef struct packed {
    logic    edgeSeen;     // one-cycle pulse after an accepted receive transition
    logic    endedActive;  // level of the segment that just ended
    symCls_t cls;          // width class of that segment
    logic    idle;         // passive for at least the idle time
    logic    echoLate;     // active drive without echo for a long-symbol time
  } dpStat_t;

  // control -> datapath
  typedef struct packed {
    logic txLevel;
  } ctlStrb_t;

endpackage

// File: rtl/vpw_datapath.sv
module vpw_datapath
  import vpw_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int FILT_N   = 3,
  parameter int LONG_T   = 128,
  parameter int IDLE_T   = 300,
  parameter int SPLIT_SL = 96,
  parameter int SPLIT_LS = 164,
  parameter int FAST_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             fastMode,
  input  logic             rxIn,
  input  ctlStrb_t         ctl,
  output dpStat_t          stat,
  output logic [CNT_W-1:0] timer
);

  localparam logic [CNT_W-1:0] T_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] T_LONG  = CNT_W'(LONG_T);
  localparam logic [CNT_W-1:0] T_IDLE  = CNT_W'(IDLE_T);
  localparam logic [CNT_W-1:0] T_SL    = CNT_W'(SPLIT_SL);
  localparam logic [CNT_W-1:0] T_LS    = CNT_W'(SPLIT_LS);

  logic [FILT_N-1:0] smp;
  logic              rxLvl;     // filtered receive level, 1 = passive
  logic [CNT_W-1:0]  segLen;
  logic [CNT_W-1:0]  echoCnt;
  logic              edgeP;
  logic              endAct;
  logic [CNT_W-1:0]  step;
  logic              agreeHi;
  logic              agreeLo;

  assign step    = fastMode ? CNT_W'(FAST_STEP) : CNT_W'(1);
  assign agreeHi = &smp;
  assign agreeLo = ~|smp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      smp     <= '1;
      rxLvl   <= 1'b1;
      timer   <= '0;
      segLen  <= '0;
      echoCnt <= '0;
      edgeP   <= 1'b0;
      endAct  <= 1'b0;
    end else begin
      edgeP <= 1'b0;
      if (tick) begin
        smp <= {smp[FILT_N-2:0], rxIn};
        if ((agreeHi && !rxLvl) || (agreeLo && rxLvl)) begin
          rxLvl  <= agreeHi;
          edgeP  <= 1'b1;
          segLen <= timer;
          endAct <= !rxLvl;
          timer  <= '0;
        end else if (timer <= T_MAX - step) begin
          timer <= timer + step;
        end
        if (ctl.txLevel && rxLvl) begin
          if (echoCnt < T_LONG) echoCnt <= echoCnt + step;
        end else begin
          echoCnt <= '0;
        end
      end
    end
  end

  always_comb begin
    stat.edgeSeen    = edgeP;
    stat.endedActive = endAct;
    if (segLen < T_SL)      stat.cls = CLS_SHORT;
    else if (segLen < T_LS) stat.cls = CLS_LONG;
    else                    stat.cls = endAct ? CLS_SOF : CLS_BREAK;
    stat.idle     = rxLvl && (timer >= T_IDLE);
    stat.echoLate = echoCnt >= T_LONG;
  end

endmodule

// File: rtl/vpw_control.sv
module vpw_control
  import vpw_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int SHORT_T = 64,
  parameter int LONG_T  = 128,
  parameter int SOF_T   = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  dpStat_t          stat,
  input  logic [CNT_W-1:0] timer,
  input  logic             txValid,
  input  logic             txBit,
  output logic             txReady,
  output logic             txBusy,
  output logic             txOut,
  output logic             rxBitValid,
  output logic             rxBit,
  output logic             collision,
  output logic             noEcho,
  output ctlStrb_t         ctl
);

  localparam logic [CNT_W-1:0] T_SHORT = CNT_W'(SHORT_T);
  localparam logic [CNT_W-1:0] T_LONG  = CNT_W'(LONG_T);
  localparam logic [CNT_W-1:0] T_SOF   = CNT_W'(SOF_T);

  logic             anchored;
  logic             toggled;
  logic             symActive;
  symCls_t          symCls;
  logic             pendV;
  logic             pendBit;
  logic             inFrame;
  logic [CNT_W-1:0] target;
  logic             accept;

  always_comb begin
    case (symCls)
      CLS_SOF:  target = T_SOF;
      CLS_LONG: target = T_LONG;
      default:  target = T_SHORT;
    endcase
  end

  assign txReady     = txBusy ? !pendV : stat.idle;
  assign accept      = txValid && txReady;
  assign ctl.txLevel = txOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy     <= 1'b0;
      txOut      <= 1'b0;
      anchored   <= 1'b0;
      toggled    <= 1'b0;
      symActive  <= 1'b0;
      symCls     <= CLS_SHORT;
      pendV      <= 1'b0;
      pendBit    <= 1'b0;
      inFrame    <= 1'b0;
      rxBitValid <= 1'b0;
      rxBit      <= 1'b0;
      collision  <= 1'b0;
      noEcho     <= 1'b0;
    end else begin
      rxBitValid <= 1'b0;
      if (stat.idle) begin
        collision <= 1'b0;
        inFrame   <= 1'b0;
      end

      // receive decode
      if (stat.edgeSeen) begin
        if (stat.cls == CLS_SOF) inFrame <= 1'b1;
        else if (stat.cls == CLS_BREAK) inFrame <= 1'b0;
        else if (inFrame) begin
          rxBitValid <= 1'b1;
          rxBit      <= stat.endedActive ? (stat.cls == CLS_SHORT) : (stat.cls == CLS_LONG);
        end
      end

      // transmit
      if (txBusy) begin
        if (accept) begin
          pendV   <= 1'b1;
          pendBit <= txBit;
        end
        if (stat.echoLate) begin
          noEcho <= 1'b1;
          txBusy <= 1'b0;
          txOut  <= 1'b0;
          pendV  <= 1'b0;
        end else if (stat.edgeSeen) begin
          if (!anchored) begin
            anchored <= 1'b1;
          end else if (stat.endedActive != symActive || stat.cls != symCls) begin
            collision <= 1'b1;
            txBusy    <= 1'b0;
            txOut     <= 1'b0;
            pendV     <= 1'b0;
          end else if (pendV) begin
            symActive <= !stat.endedActive;
            symCls    <= ((!stat.endedActive) ^ pendBit) ? CLS_LONG : CLS_SHORT;
            pendV     <= 1'b0;
            toggled   <= 1'b0;
          end else begin
            txBusy <= 1'b0;
          end
        end else if (tick && anchored && !toggled && timer >= target) begin
          toggled <= 1'b1;
          if (symActive)  txOut  <= 1'b0;
          else if (pendV) txOut  <= 1'b1;
          else            txBusy <= 1'b0;
        end
      end else if (accept) begin
        txBusy    <= 1'b1;
        txOut     <= 1'b1;
        anchored  <= 1'b0;
        toggled   <= 1'b0;
        symActive <= 1'b1;
        symCls    <= CLS_SOF;
        pendV     <= 1'b1;
        pendBit   <= txBit;
        noEcho    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vpw_sym_xcvr.sv
module vpw_sym_xcvr
  import vpw_pkg::*;
#(
  parameter int SHORT_T   = 64,
  parameter int LONG_T    = 128,
  parameter int SOF_T     = 200,
  parameter int IDLE_T    = 300,
  parameter int SPLIT_SL  = 96,
  parameter int SPLIT_LS  = 164,
  parameter int FILT_N    = 3,
  parameter int FAST_STEP = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic fastMode,
  input  logic rxIn,
  input  logic txValid,
  input  logic txBit,
  output logic txReady,
  output logic txOut,
  output logic txBusy,
  output logic rxBitValid,
  output logic rxBit,
  output logic collision,
  output logic noEcho,
  output logic busIdle
);

  localparam int CNT_W = $clog2(IDLE_T + 1) + 1;

  dpStat_t          stat;
  ctlStrb_t         ctl;
  logic [CNT_W-1:0] timer;

  vpw_datapath #(
    .CNT_W(CNT_W), .FILT_N(FILT_N), .LONG_T(LONG_T), .IDLE_T(IDLE_T),
    .SPLIT_SL(SPLIT_SL), .SPLIT_LS(SPLIT_LS), .FAST_STEP(FAST_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .fastMode(fastMode), .rxIn(rxIn),
    .ctl(ctl), .stat(stat), .timer(timer)
  );

  vpw_control #(
    .CNT_W(CNT_W), .SHORT_T(SHORT_T), .LONG_T(LONG_T), .SOF_T(SOF_T)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .tick(tick), .stat(stat), .timer(timer),
    .txValid(txValid), .txBit(txBit), .txReady(txReady), .txBusy(txBusy),
    .txOut(txOut), .rxBitValid(rxBitValid), .rxBit(rxBit),
    .collision(collision), .noEcho(noEcho), .ctl(ctl)
  );

  assign busIdle = stat.idle;

endmodule

// File: rtl/vpw_checker.sv
module vpw_checker (
  input logic clk,
  input logic rstN,
  input logic txReady,
  input logic txOut,
  input logic txBusy,
  input logic rxBitValid,
  input logic collision,
  input logic noEcho,
  input logic busIdle
);

  AST_COLL_LINE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    collision |-> !txOut);  // R9

  AST_COLL_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(collision) |-> $past(busIdle));  // R9

  AST_NOECHO_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    noEcho |-> !txBusy);  // R10

  AST_START_ON_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> $past(busIdle));  // R4

  AST_DRIVE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    txOut |-> txBusy);  // R8

  AST_RXBIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxBitValid |=> !rxBitValid);  // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> (txReady == busIdle));  // R4

endmodule

bind vpw_sym_xcvr vpw_checker u_chk (.*);

// File: tb/sim_vpw_sym_xcvr.sv
`timescale 1ns/1ps
module sim_vpw_sym_xcvr;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fastMode = 1'b0;
  logic txValid = 1'b0;
  logic txBit = 1'b0;
  logic other = 1'b0;
  logic echoCut = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic [3:0] dly = 4'd0;
  logic tick, rxIn;
  logic txReady, txOut, txBusy, rxBitValid, rxBit, collision, noEcho, busIdle;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  bit chkRx = 0;
  int expQ[$];
  int segLvl[$];
  int segLen[$];
  int segCyc = 0;
  logic lastTx = 1'b0;

  always #4 clk = ~clk;

  assign tick = (tdiv == 2'd0);
  assign rxIn = ~((dly[3] & !echoCut) | other);

  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    dly  <= {dly[2:0], txOut};
  end

  vpw_sym_xcvr u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .fastMode(fastMode), .rxIn(rxIn),
    .txValid(txValid), .txBit(txBit), .txReady(txReady), .txOut(txOut),
    .txBusy(txBusy), .rxBitValid(rxBitValid), .rxBit(rxBit),
    .collision(collision), .noEcho(noEcho), .busIdle(busIdle)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  endtask

  // segment recorder on the transmit line
  always @(negedge clk) begin
    if (txOut != lastTx) begin
      segLvl.push_back(int'(lastTx));
      segLen.push_back(segCyc);
      segCyc = 1;
    end else begin
      segCyc++;
    end
    lastTx = txOut;
  end

  // decoded-bit reference comparison, every clock
  always @(negedge clk) begin
    if (rxBitValid && chkRx) begin
      if (expQ.size() == 0) check(0, "R7 unexpected bit", int'(rxBit), -1);
      else begin
        int e;
        e = expQ.pop_front();
        check(int'(rxBit) == e, "R7 decoded bit", int'(rxBit), e);
      end
    end
  end

  task automatic waitTicks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic pushBit(input logic b);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txValid = 1'b1;
    txBit   = b;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic sendFrame(input int n, input logic [15:0] bits, input int div, input string tag);
    for (int i = 0; i < n; i++) expQ.push_back(int'(bits[i]));
    chkRx = 1;
    pushBit(bits[0]);
    while (!txOut) @(negedge clk);
    @(negedge clk);
    segLvl.delete();
    segLen.delete();
    for (int i = 1; i < n; i++) pushBit(bits[i]);
    while (txBusy) @(negedge clk);
    waitTicks(20);
    check(segLen.size() == n + 1, {tag, " R8 symbol count"}, segLen.size(), n + 1);
    if (segLen.size() == n + 1) begin
      int w;
      w = (segLen[0] + 2) / 4;
      check(segLvl[0] == 1 && w >= 200 / div && w <= 200 / div + 12,
            {tag, " R5 start-of-frame width"}, w, 200 / div);
      for (int i = 0; i < n; i++) begin
        int lvl, t;
        lvl = i % 2;
        t = ((lvl ^ int'(bits[i])) != 0 ? 128 : 64) / div;
        w = (segLen[i + 1] + 2) / 4;
        check(segLvl[i + 1] == lvl, {tag, " R6 symbol level"}, segLvl[i + 1], lvl);
        check(w >= t && w <= t + 12, {tag, " R6 symbol width"}, w, t);
      end
    end
    check(expQ.size() == 0, {tag, " R7 all bits decoded"}, expQ.size(), 0);
    check(collision == 0 && txBusy == 0, {tag, " R8 clean frame end"}, int'(collision), 0);
    chkRx = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int t0, w;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txOut == 0 && txBusy == 0, "R1 tx lines after reset", int'(txOut), 0);
    check(collision == 0 && noEcho == 0 && rxBitValid == 0, "R1 flags after reset", int'(collision), 0);
    check(busIdle == 0 && txReady == 0, "R1 not idle after reset, R4 no ready", int'(busIdle), 0);

    // R3 idle time
    t0 = 1;
    while (!busIdle) begin @(negedge clk); t0++; end
    w = t0 / 4;
    check(w >= 297 && w <= 303, "R3 idle after passive time", w, 300);
    check(txReady == 1, "R4 ready when idle", int'(txReady), 1);

    // R2 noise rejection
    chkRx = 1;
    other = 1'b1;
    repeat (6) @(negedge clk);
    other = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!busIdle) begin check(0, "R2 noise cleared idle", 0, 1); break; end
    end
    check(busIdle == 1, "R2 idle kept through short pulse", int'(busIdle), 1);
    chkRx = 0;

    // R5 R6 R7 R8 normal frame
    sendFrame(8, 16'b1001_0110, 1, "normal");
    while (!busIdle) @(negedge clk);

    // R10 no echo
    echoCut = 1'b1;
    pushBit(1'b1);
    waitTicks(100);
    check(noEcho == 0 && txOut == 1, "R10 no early noEcho", int'(noEcho), 0);
    waitTicks(40);
    check(noEcho == 1, "R10 noEcho raised", int'(noEcho), 1);
    check(txOut == 0 && txBusy == 0, "R10 transmission stopped", int'(txBusy), 0);
    echoCut = 1'b0;
    waitTicks(10);

    // R11 fast mode frame
    fastMode = 1'b1;
    waitTicks(80);
    check(busIdle == 1, "R11 idle in fast mode", int'(busIdle), 1);
    sendFrame(4, 16'b1001, 4, "fast");
    check(noEcho == 0, "R10 noEcho cleared by new frame", int'(noEcho), 0);
    fastMode = 1'b0;
    waitTicks(310);

    // R9 collision: our passive long cut short by another node
    check(busIdle == 1, "R3 idle before collision test", int'(busIdle), 1);
    pushBit(1'b1);
    while (!txOut) @(negedge clk);
    while (txOut) @(negedge clk);
    pushBit(1'b0);
    waitTicks(60);
    other = 1'b1;
    waitTicks(80);
    check(collision == 1, "R9 collision raised", int'(collision), 1);
    check(txOut == 0 && txBusy == 0, "R9 transmission withdrawn", int'(txOut), 0);
    other = 1'b0;
    waitTicks(20);
    check(collision == 1, "R9 collision held before idle", int'(collision), 1);
    check(txReady == 0, "R4 no ready while bus not idle", int'(txReady), 0);
    while (!busIdle) @(negedge clk);
    repeat (2) @(negedge clk);
    check(collision == 0, "R9 collision cleared at idle", int'(collision), 0);

    // R7 receive-only frame from another node
    expQ = {0, 1, 1, 0, 1, 1};
    chkRx = 1;
    other = 1'b1; waitTicks(10);
    check(busIdle == 0, "R3 idle dropped on active", int'(busIdle), 0);
    waitTicks(190);
    other = 1'b0; waitTicks(64);
    other = 1'b1; waitTicks(64);
    other = 1'b0; waitTicks(128);
    other = 1'b1; waitTicks(128);
    other = 1'b0; waitTicks(100);
    other = 1'b1; waitTicks(92);
    other = 1'b0; waitTicks(320);
    check(expQ.size() == 0, "R7 receive-only bits", expQ.size(), 0);
    check(txBusy == 0 && txOut == 0, "R7 receive leaves transmitter quiet", int'(txOut), 0);
    chkRx = 0;

    finishRun();
  end

endmodule